// File: doc/BRIEF.md
# In-Order Commit Reorder Buffer for Compressed Pixel Packets

This block puts compressed pixel packets back into raster order after they leave processing lanes whose latencies differ. Upstream, each input batch of `N` pixels claims `N` consecutive entries in one cycle. The entry addresses come back as tags, and each tag travels with its pixel through whichever lane handles it.

When a lane finishes, it presents the tag and the packet on one of `N` completion ports. The packet lands in the entry that the tag names, and that entry becomes valid. On the output side the oldest allocated entry is watched. It is emitted, at most one per cycle, only once it is valid. Younger entries that are already valid wait behind it.

Packet contents are opaque to the buffer. A completion that names an entry outside the allocated window, or an entry that is already valid, is discarded and latches an error flag.

Top module: `tag_reorder_buf`

## Requirements
- R1: After reset, `alloc_rdy` is 1, `out_vld` is 0 and `err` is 0.
- R2: An accepted allocation (`alloc_req` and `alloc_rdy` both high) returns `N` consecutive tags on `alloc_tags`. Lane i holds bits `[i*AW +: AW]` and carries base+i. The base starts at 0 after reset and advances by `N` for each accepted batch.
- R3: `alloc_rdy` is low exactly when fewer than `N` entries are free. A request made while it is low reserves nothing and does not move the allocation base.
- R4: A completion accepted at a clock edge for the oldest allocated entry shows that entry on `out_vld`/`out_tag`/`out_data` right after that edge.
- R5: Entries leave strictly in allocation order. A valid younger entry is never emitted while the oldest allocated entry is still waiting for its completion.
- R6: At most one entry is emitted per cycle, and emitted entries keep coming on consecutive cycles while they are valid. An emitted entry is freed and its valid flag cleared. `out_tag` equals the entry address.
- R7: Up to `N` completions to distinct tags are accepted in one cycle, presented on any lanes in any order.
- R8: A completion to an entry that is not allocated, or that is already valid, sets `err`. The flag stays set until reset, and the bad write changes neither the contents nor the valid flag of any entry.
- R9: Tags and the commit position wrap from `DEPTH-1` to 0. After the buffer has been filled and partly drained, the next batch reuses the lowest addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Request to reserve one batch of N entries |
| alloc_rdy | output | 1 | At least N entries are free |
| alloc_tags | output | N*AW | Tags of the batch; lane i in bits [i*AW +: AW] |
| wr_vld | input | N | Completion valid, one bit per lane |
| wr_tag | input | N*AW | Completion tag per lane |
| wr_data | input | N*DW | Completion packet per lane |
| out_vld | output | 1 | Oldest entry is valid and is emitted this cycle |
| out_tag | output | AW | Address of the emitted entry |
| out_data | output | DW | Packet of the emitted entry |
| err | output | 1 | Sticky flag for a bad completion write |

## Verification
Hard to reach from the ports: the buffer completely full with only some of its oldest entries drained, so that free space sits just under and then exactly at one batch, and the allocation that follows has to wrap to address 0. The bench gets there by claiming every batch back to back, then completing the first entries one lane at a time and watching `alloc_rdy` at each step. It then feeds the whole remaining range through the completion lanes and checks that the emitted stream crosses from the top address to 0 with the packets of the second pass.

// File: rtl/tag_reorder_buf.sv
module tag_reorder_buf #(
  parameter int N     = 4,
  parameter int DEPTH = 2048,
  parameter int DW    = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_req,
  output logic            alloc_rdy,
  output logic [N*$clog2(DEPTH)-1:0] alloc_tags,
  input  logic [N-1:0]    wr_vld,
  input  logic [N*$clog2(DEPTH)-1:0] wr_tag,
  input  logic [N*DW-1:0] wr_data,
  output logic            out_vld,
  output logic [$clog2(DEPTH)-1:0] out_tag,
  output logic [DW-1:0]   out_data,
  output logic            err
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0]    wp, rp, used;
  logic [DEPTH-1:0] vld;
  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    head;
  logic             alloc_go;
  logic [AW-1:0]    tag_a [N];
  logic [AW-1:0]    offs  [N];
  logic [N-1:0]     dup, bad, ok;

  assign used      = wp - rp;
  assign head      = rp[AW-1:0];
  assign alloc_rdy = used <= PW'(DEPTH - N);
  assign alloc_go  = alloc_req && alloc_rdy;
  assign out_vld   = vld[head];
  assign out_tag   = head;
  assign out_data  = mem[head];

  for (genvar g = 0; g < N; g++) begin : g_tag
    assign alloc_tags[g*AW +: AW] = wp[AW-1:0] + AW'(g);
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      tag_a[i] = wr_tag[i*AW +: AW];
      offs[i]  = tag_a[i] - head;
      dup[i]   = 1'b0;
      for (int j = 0; j < i; j++)
        if (wr_vld[j] && tag_a[j] == tag_a[i]) dup[i] = 1'b1;
      bad[i] = wr_vld[i] && (({1'b0, offs[i]} >= used) || vld[tag_a[i]] || dup[i]);
      ok[i]  = wr_vld[i] && !bad[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      vld <= '0;
      err <= 1'b0;
    end else begin
      if (alloc_go) wp <= wp + PW'(N);
      if (out_vld) begin
        rp        <= rp + PW'(1);
        vld[head] <= 1'b0;
      end
      for (int i = 0; i < N; i++)
        if (ok[i]) vld[tag_a[i]] <= 1'b1;
      err <= err | (|bad);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++)
      if (ok[i]) mem[tag_a[i]] <= wr_data[i*DW +: DW];
  end
endmodule

// File: rtl/tag_reorder_buf_chk.sv
module tag_reorder_buf_chk #(
  parameter int N     = 4,
  parameter int DEPTH = 2048,
  parameter int DW    = 16
) (
  input logic clk,
  input logic rst_n,
  input logic alloc_req,
  input logic alloc_rdy,
  input logic [N*$clog2(DEPTH)-1:0] alloc_tags,
  input logic out_vld,
  input logic [$clog2(DEPTH)-1:0] out_tag,
  input logic err
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] cnt;
  logic [AW-1:0] exp_head, exp_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      exp_head <= '0;
      exp_base <= '0;
    end else begin
      cnt <= cnt + ((alloc_req && alloc_rdy) ? PW'(N) : PW'(0)) - (out_vld ? PW'(1) : PW'(0));
      if (alloc_req && alloc_rdy) exp_base <= exp_base + AW'(N);
      if (out_vld) exp_head <= exp_head + AW'(1);
    end
  end

  p_alloc_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && alloc_rdy) |-> alloc_tags[AW-1:0] == exp_base);
  p_rdy_space_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_rdy == (cnt <= PW'(DEPTH - N)));
  p_commit_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> out_tag == exp_head);
  p_empty_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> !out_vld);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

bind tag_reorder_buf tag_reorder_buf_chk #(.N(N), .DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_rdy(alloc_rdy),
  .alloc_tags(alloc_tags), .out_vld(out_vld), .out_tag(out_tag), .err(err)
);

// File: tb/tb_tag_reorder_buf.sv
`timescale 1ns/100ps
module tb_tag_reorder_buf;
  localparam int N = 4, DEPTH = 2048, DW = 16, AW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0, alloc_req = 0;
  logic alloc_rdy, out_vld, err;
  logic [N*AW-1:0] alloc_tags, wr_tag = '0;
  logic [N-1:0] wr_vld = '0;
  logic [N*DW-1:0] wr_data = '0;
  logic [AW-1:0] out_tag;
  logic [DW-1:0] out_data;

  tag_reorder_buf #(.N(N), .DEPTH(DEPTH), .DW(DW)) dut (.*);

  always #2.5 clk = ~clk;

  int n_tests = 0, n_fail = 0, cyc = 0, nlog = 0, last_wr = 0;
  logic [AW-1:0] log_tag [4096];
  logic [DW-1:0] log_dat [4096];
  int log_cyc [4096];
  logic [AW-1:0] got [N];
  logic got_rdy;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && out_vld && nlog < 4096) begin
    log_tag[nlog] = out_tag; log_dat[nlog] = out_data; log_cyc[nlog] = cyc; nlog++;
  end

  function automatic logic [DW-1:0] dfn(int t, int s);
    return DW'(t * 37 + s * 1001 + 5);
  endfunction

  task automatic chk(bit c, string req, int act, int exp);
    n_tests++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 0; alloc_req = 0; wr_vld = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1; nlog = 0;
  endtask

  task automatic alloc();
    @(posedge clk); #1;
    alloc_req = 1;
    #1 got_rdy = alloc_rdy;
    for (int i = 0; i < N; i++) got[i] = alloc_tags[i*AW +: AW];
    @(posedge clk); #1 alloc_req = 0;
  endtask

  task automatic wr(logic [N-1:0] m, int t0, int t1, int t2, int t3, int s);
    int t [N];
    t[0] = t0; t[1] = t1; t[2] = t2; t[3] = t3;
    @(posedge clk); #1;
    wr_vld = m;
    for (int i = 0; i < N; i++) begin
      wr_tag[i*AW +: AW] = AW'(t[i]);
      wr_data[i*DW +: DW] = dfn(t[i], s);
    end
    last_wr = cyc;
    @(posedge clk); #1 wr_vld = '0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(alloc_rdy == 1, "R1 alloc_rdy", alloc_rdy, 1);
    chk(out_vld == 0, "R1 out_vld", out_vld, 0);
    chk(err == 0, "R1 err", err, 0);
  endtask

  task automatic t_alloc();
    int bad = 0;
    alloc();
    for (int i = 0; i < N; i++) if (got[i] != AW'(i)) bad++;
    chk(got_rdy && bad == 0, "R2 first batch tags", bad, 0);
    alloc();
    bad = 0;
    for (int i = 0; i < N; i++) if (got[i] != AW'(4 + i)) bad++;
    chk(bad == 0, "R2 second batch tags", int'(got[0]), 4);
  endtask

  task automatic t_ooo();
    int bad = 0;
    wr(4'b0011, 3, 2, 0, 0, 0);
    idle(3);
    chk(nlog == 0, "R5 younger valid held behind head", nlog, 0);
    wr(4'b0001, 1, 0, 0, 0, 0);
    idle(2);
    chk(nlog == 0, "R5 still waiting on head", nlog, 0);
    wr(4'b0001, 0, 0, 0, 0, 0);
    idle(6);
    chk(nlog == 4, "R6 four commits", nlog, 4);
    chk(log_cyc[0] == last_wr + 1, "R4 head latency", log_cyc[0], last_wr + 1);
    for (int i = 0; i < 4; i++)
      if (log_tag[i] != AW'(i) || log_dat[i] != dfn(i, 0) || log_cyc[i] != log_cyc[0] + i) bad++;
    chk(bad == 0, "R6 order, data, one per cycle", bad, 0);
    wr(4'b1111, 7, 6, 5, 4, 0);
    idle(8);
    bad = 0;
    for (int i = 4; i < 8; i++)
      if (log_tag[i] != AW'(i) || log_dat[i] != dfn(i, 0)) bad++;
    chk(nlog == 8 && bad == 0, "R7 four lanes one cycle", bad, 0);
    chk(!out_vld && alloc_rdy, "R6 drained entries freed", out_vld, 0);
  endtask

  task automatic t_full();
    int bad = 0;
    do_reset();
    for (int b = 0; b < DEPTH / N; b++) begin
      alloc();
      if (!got_rdy || got[0] != AW'(b * N)) bad++;
    end
    chk(bad == 0, "R2 fill all batches", bad, 0);
    chk(alloc_rdy == 0, "R3 full not ready", alloc_rdy, 0);
    alloc();
    wr(4'b0001, 0, 0, 0, 0, 0);
    idle(3);
    chk(alloc_rdy == 0, "R3 one free entry not enough", alloc_rdy, 0);
    wr(4'b0111, 1, 2, 3, 0, 0);
    idle(4);
    chk(alloc_rdy == 1, "R3 ready with N free", alloc_rdy, 1);
    alloc();
    bad = 0;
    for (int i = 0; i < N; i++) if (got[i] != AW'(i)) bad++;
    chk(got_rdy && bad == 0, "R9 wrapped batch tags", int'(got[0]), 0);
    for (int b = 1; b < DEPTH / N; b++)
      wr(4'b1111, b*N, b*N+1, b*N+2, b*N+3, 0);
    wr(4'b1111, 2, 0, 3, 1, 1);
    idle(2200);
    bad = 0;
    for (int i = 0; i < DEPTH; i++)
      if (log_tag[i] != AW'(i) || log_dat[i] != dfn(i, 0)) bad++;
    chk(nlog == DEPTH + N && bad == 0, "R5 full pass order", bad, 0);
    bad = 0;
    for (int i = 0; i < N; i++)
      if (log_tag[DEPTH+i] != AW'(i) || log_dat[DEPTH+i] != dfn(i, 1)) bad++;
    chk(bad == 0, "R9 commit wraps to 0", bad, 0);
  endtask

  task automatic t_err_unalloc();
    do_reset();
    wr(4'b0001, 0, 0, 0, 0, 0);
    idle(2);
    chk(err == 1, "R8 write to unallocated", err, 1);
    alloc();
    idle(4);
    chk(nlog == 0, "R8 unallocated write ignored", nlog, 0);
    wr(4'b1111, 0, 1, 2, 3, 2);
    idle(6);
    chk(nlog == 4 && log_dat[0] == dfn(0, 2), "R8 later writes normal", nlog, 4);
    chk(err == 1, "R8 err sticky", err, 1);
  endtask

  task automatic t_err_double();
    do_reset();
    alloc();
    wr(4'b0001, 2, 0, 0, 0, 0);
    idle(1);
    chk(err == 0, "R8 first write clean", err, 1'b0);
    wr(4'b0001, 2, 0, 0, 0, 3);
    idle(2);
    chk(err == 1, "R8 write to valid entry", err, 1);
    wr(4'b0111, 0, 1, 3, 0, 0);
    idle(6);
    chk(nlog == 4 && log_dat[2] == dfn(2, 0), "R8 second write ignored", int'(log_dat[2]), int'(dfn(2, 0)));
  endtask

  initial begin
    t_reset();
    t_alloc();
    t_ooo();
    t_full();
    t_err_unalloc();
    t_err_double();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule